// File: doc/BRIEF.md
# Dual Wiper Register Bank with Non-Volatile Shadow

This block keeps the register state of a two-channel digital potentiometer controller. Each channel owns a live 8-bit wiper code and a stored initial code, and the two share one register address. A mode bit in a control register decides whether an access reaches the stored copy or only the live copy. Thirteen general-purpose stored bytes sit beside the channels. A reserved address never holds data. A serial-bus front end presents single-cycle write strobes and a read address. The bank returns read data combinationally and drives the two wiper codes, a shutdown flag and a busy flag.

A write to stored memory takes a fixed number of cycles. During that time a counter keeps the busy flag raised and every write is refused. There are two resets. The power-on reset restores the factory contents everywhere. The soft reset restores only the volatile state: it copies the stored codes back into the live wipers and returns the control register to its default.

Top module: `wiper_bank`

## Requirements
- R1: After power-on reset both wiper outputs and both stored codes are 0x80, every general-purpose byte is 0x00, address 0x10 reads 0x40, and shutdown and busy are 0.
- R2: With the mode bit (bit 7 of 0x10) at 0, a write to 0x00 (channel A) or 0x01 (channel B) updates both the stored code and the live wiper. The wiper output shows the new code in the cycle after the write edge.
- R3: With the mode bit at 1, a write to 0x00 or 0x01 changes only the live wiper and does not raise busy. A read of 0x00 or 0x01 returns the live code when the bit is 1 and the stored code when it is 0.
- R4: At address 0x10, bit 7 is the mode bit, bit 6 is the active-low run bit, bit 5 is the read-only busy bit, and bits 4..0 read 0. A write there takes only bits 7 and 6.
- R5: The shutdown output is 1 exactly while the run bit (bit 6 of 0x10) is 0.
- R6: An accepted write to stored memory raises busy, and bit 5 of 0x10 with it, for exactly NV_BUSY_CYCLES cycles after the write edge.
- R7: Every write presented while busy is 1 is ignored.
- R8: Addresses 0x02..0x0E are stored general-purpose bytes. A write to one is accepted in either mode and raises busy. Each byte reads back its value and leaves both wipers unchanged.
- R9: Writes to 0x0F and to any address above 0x10 are discarded and raise no busy. Those addresses read 0x00.
- R10: While softRstN is low at a clock edge, each live wiper reloads its stored code, address 0x10 returns to 0x40 and busy clears. Stored codes and general-purpose bytes are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low, restores factory contents |
| softRstN | input | 1 | Synchronous soft reset, active low, restores volatile state only |
| wrEn | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| wiperA | output | 8 | Channel A live wiper code |
| wiperB | output | 8 | Channel B live wiper code |
| shutdown | output | 1 | High while both channels are shut down |
| busy | output | 1 | High while a stored-memory write is pending |

## Verification
A write takes effect on the clock edge that samples the strobe. The wiper outputs, shutdown and busy change one register stage later, so they are correct in the cycle after that edge. Read data needs no cycle: it follows the address and the current state combinationally. The busy window ends exactly NV_BUSY_CYCLES edges after the accepting edge. The bench changes inputs shortly after each rising edge. It steps a behavioural model on the same edge and compares all outputs on the falling edge. Directed sequences read results a few nanoseconds after the write edge, and they count busy cycles edge by edge.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int CH_NUM   = 2;
  localparam int GP_NUM   = 13;
  localparam int GP_IDX_W = $clog2(GP_NUM);

  localparam logic [ADDR_W-1:0] GP_FIRST  = 8'h02;
  localparam logic [ADDR_W-1:0] GP_LAST   = 8'h0E;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h10;

  localparam logic [DATA_W-1:0] WIPER_INIT = 8'h80;
  localparam logic [DATA_W-1:0] GP_INIT    = 8'h00;

  localparam int VOL_BIT  = 7;
  localparam int SHDN_BIT = 6;
  localparam int WIP_BIT  = 5;

  // Strobes from the control unit to the register datapath
  typedef struct packed {
    logic [CH_NUM-1:0]   nvWiperWr;
    logic [CH_NUM-1:0]   liveWiperWr;
    logic                gpWr;
    logic [GP_IDX_W-1:0] gpIdx;
    logic                ctrlWr;
    logic [DATA_W-1:0]   data;
  } wbStrobe_t;
endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wb_pkg::*;
#(
  parameter int NV_BUSY_CYCLES = 20
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              volIn,
  output wbStrobe_t         strobe,
  output logic              wip
);
  localparam int CNT_W = $clog2(NV_BUSY_CYCLES + 1);

  logic [CNT_W-1:0]  busyCnt;
  logic              accept;
  logic              gpHit;
  logic              nvStart;
  logic [CH_NUM-1:0] chHit;

  assign accept = wrEn && softRstN && !wip;
  assign gpHit  = (addr >= GP_FIRST) && (addr <= GP_LAST);

  generate
    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chDec
      assign chHit[ch] = (addr == ADDR_W'(ch));
    end
  endgenerate

  always_comb begin
    strobe       = '0;
    strobe.data  = wrData;
    strobe.gpIdx = GP_IDX_W'(addr - GP_FIRST);
    if (accept) begin
      strobe.liveWiperWr = chHit;
      strobe.nvWiperWr   = volIn ? '0 : chHit;
      strobe.gpWr        = gpHit;
      strobe.ctrlWr      = (addr == CTRL_ADDR);
    end
  end

  assign nvStart = (|strobe.nvWiperWr) || strobe.gpWr;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      busyCnt <= '0;
    end else if (!softRstN) begin
      busyCnt <= '0;
    end else if (nvStart) begin
      busyCnt <= CNT_W'(NV_BUSY_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  assign wip = (busyCnt != '0);

  // R6: a stored wiper write, once accepted, raises the busy flag
  p_nv_start_r6: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && softRstN && !wip && !volIn && addr < ADDR_W'(CH_NUM)) |=> wip);

  // R8: a general-purpose write raises the busy flag
  p_gp_start_r8: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && softRstN && !wip && addr >= GP_FIRST && addr <= GP_LAST) |=> wip);

  // R3: a live-only wiper write leaves the bank idle
  p_live_idle_r3: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && softRstN && !wip && volIn && addr < ADDR_W'(CH_NUM)) |=> !wip);

  // R10: soft reset clears a pending busy window
  p_soft_idle_r10: assert property (@(posedge clk) disable iff (!porRstN)
    !softRstN |=> !wip);
endmodule

// File: rtl/wb_data.sv
module wb_data
  import wb_pkg::*;
(
  input  logic                          clk,
  input  logic                          porRstN,
  input  logic                          softRstN,
  input  wbStrobe_t                     strobe,
  input  logic                          wip,
  input  logic [ADDR_W-1:0]             addr,
  output logic [CH_NUM-1:0][DATA_W-1:0] wiper,
  output logic                          shdnQ,
  output logic                          volQ,
  output logic [DATA_W-1:0]             rdData
);
  logic [CH_NUM-1:0][DATA_W-1:0] nvQ;
  logic [CH_NUM-1:0][DATA_W-1:0] liveQ;
  logic [GP_NUM-1:0][DATA_W-1:0] gpQ;

  generate
    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
      logic [DATA_W-1:0] nvReg;
      logic [DATA_W-1:0] liveReg;

      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) begin
          nvReg <= WIPER_INIT;
        end else if (softRstN && strobe.nvWiperWr[ch]) begin
          nvReg <= strobe.data;
        end
      end

      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) begin
          liveReg <= WIPER_INIT;
        end else if (!softRstN) begin
          liveReg <= nvReg;
        end else if (strobe.liveWiperWr[ch]) begin
          liveReg <= strobe.data;
        end
      end

      assign nvQ[ch]   = nvReg;
      assign liveQ[ch] = liveReg;
      assign wiper[ch] = liveReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      for (int g = 0; g < GP_NUM; g++) gpQ[g] <= GP_INIT;
    end else if (softRstN && strobe.gpWr) begin
      for (int g = 0; g < GP_NUM; g++) begin
        if (strobe.gpIdx == GP_IDX_W'(g)) gpQ[g] <= strobe.data;
      end
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      volQ  <= 1'b0;
      shdnQ <= 1'b1;
    end else if (!softRstN) begin
      volQ  <= 1'b0;
      shdnQ <= 1'b1;
    end else if (strobe.ctrlWr) begin
      volQ  <= strobe.data[VOL_BIT];
      shdnQ <= strobe.data[SHDN_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < CH_NUM; ch++) begin
      if (addr == ADDR_W'(ch)) rdData = volQ ? liveQ[ch] : nvQ[ch];
    end
    for (int g = 0; g < GP_NUM; g++) begin
      if (addr == GP_FIRST + ADDR_W'(g)) rdData = gpQ[g];
    end
    if (addr == CTRL_ADDR) begin
      rdData[VOL_BIT]  = volQ;
      rdData[SHDN_BIT] = shdnQ;
      rdData[WIP_BIT]  = wip;
    end
  end

  // R7: nothing programmable moves while a stored write is pending
  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!porRstN)
    (wip && softRstN) |=> ($stable(liveQ) && $stable(nvQ) && $stable(volQ) && $stable(shdnQ) && $stable(gpQ)));

  // R10: soft reset reloads the live wipers and the control defaults
  p_reload_r10: assert property (@(posedge clk) disable iff (!porRstN)
    !softRstN |=> (liveQ == nvQ && !volQ && shdnQ));

  // R8: a general-purpose write leaves the wipers alone
  p_gp_isolated_r8: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.gpWr |=> $stable(liveQ));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wb_pkg::*;
#(
  parameter int NV_BUSY_CYCLES = 20
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wiperA,
  output logic [DATA_W-1:0] wiperB,
  output logic              shutdown,
  output logic              busy
);
  wbStrobe_t                     strobe;
  logic                          wip;
  logic                          volQ;
  logic                          shdnQ;
  logic [CH_NUM-1:0][DATA_W-1:0] wiper;

  wb_ctrl #(.NV_BUSY_CYCLES(NV_BUSY_CYCLES)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .volIn(volQ), .strobe(strobe), .wip(wip)
  );

  wb_data u_data (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN), .strobe(strobe),
    .wip(wip), .addr(addr), .wiper(wiper), .shdnQ(shdnQ), .volQ(volQ),
    .rdData(rdData)
  );

  assign wiperA   = wiper[0];
  assign wiperB   = wiper[1];
  assign shutdown = !shdnQ;
  assign busy     = wip;

  // R5: shutdown tracks the run bit as read at the control address
  p_shutdown_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (addr == CTRL_ADDR) |-> (shutdown == !rdData[SHDN_BIT]));
endmodule

// File: tb/wiper_bank_test.sv
`timescale 1ns/1ps
module wiper_bank_test;
  localparam int N = 20;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       softRstN = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, wiperA, wiperB;
  logic       shutdown, busy;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  wiper_bank #(.NV_BUSY_CYCLES(N)) uut (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .wiperA(wiperA),
    .wiperB(wiperB), .shutdown(shutdown), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mNv[2];
  int mLive[2];
  int mGp[16];
  int mVol, mShdn, mCnt;
  bit mNvw;

  function automatic int mRead(input int a);
    if (a == 0 || a == 1) return mVol ? mLive[a] : mNv[a];
    if (a >= 2 && a <= 14) return mGp[a];
    if (a == 16) return mVol * 128 + mShdn * 64 + ((mCnt != 0) ? 32 : 0);
    return 0;
  endfunction

  function automatic string regionTag(input int a);
    if (a <= 1) return "R3";
    if (a <= 14) return "R8";
    if (a == 16) return "R4";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!porRstN) begin
      mNv[0] = 8'h80; mNv[1] = 8'h80; mLive[0] = 8'h80; mLive[1] = 8'h80;
      for (int i = 0; i < 16; i++) mGp[i] = 0;
      mVol = 0; mShdn = 1; mCnt = 0;
    end else if (!softRstN) begin
      mLive[0] = mNv[0]; mLive[1] = mNv[1];
      mVol = 0; mShdn = 1; mCnt = 0;
    end else begin
      mNvw = 1'b0;
      if (wrEn && mCnt == 0) begin
        if (addr <= 8'h01) begin
          mLive[addr] = wrData;
          if (mVol == 0) begin mNv[addr] = wrData; mNvw = 1'b1; end
        end else if (addr <= 8'h0E) begin
          mGp[addr] = wrData; mNvw = 1'b1;
        end else if (addr == 8'h10) begin
          mVol = wrData[7]; mShdn = wrData[6];
        end
      end
      if (mNvw) mCnt = N;
      else if (mCnt > 0) mCnt--;
    end
  end

  always @(negedge clk) begin
    if (porRstN && !done) begin
      chk("R2 wiperA model", wiperA, mLive[0]);
      chk("R2 wiperB model", wiperB, mLive[1]);
      chk("R5 shutdown model", shutdown, mShdn == 0);
      chk("R6 busy model", busy, mCnt != 0);
      chk({regionTag(addr), " read model"}, rdData, mRead(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 1000) begin n++; @(posedge clk); #2; end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk);
    #2 porRstN = 1'b1;

    // R1: power-on defaults
    chk("R1 wiperA reset", wiperA, 8'h80);
    chk("R1 wiperB reset", wiperB, 8'h80);
    chk("R1 shutdown reset", shutdown, 1'b0);
    chk("R1 busy reset", busy, 1'b0);
    rd(8'h10, v); chk("R1 control reset", v, 8'h40);
    rd(8'h00, v); chk("R1 stored A reset", v, 8'h80);
    rd(8'h05, v); chk("R1 gp reset", v, 8'h00);

    // R2: stored write updates both copies
    wr(8'h00, 8'h3C);
    chk("R2 wiperA after stored write", wiperA, 8'h3C);
    chk("R2 busy after stored write", busy, 1'b1);
    rd(8'h00, v); chk("R2 stored A readback", v, 8'h3C);

    // R7: writes during busy are dropped
    wr(8'h01, 8'h11);
    wr(8'h10, 8'h80);
    chk("R7 wiperB untouched", wiperB, 8'h80);
    rd(8'h10, v); chk("R7 control untouched, R6 wip bit", v, 8'h60);
    waitIdle();
    rd(8'h10, v); chk("R6 wip bit clear", v, 8'h40);

    // R4/R5: control write, low bits discarded
    wr(8'h10, 8'hBF);
    rd(8'h10, v); chk("R4 control readback", v, 8'h80);
    chk("R5 shutdown on", shutdown, 1'b1);
    chk("R4 no busy from control", busy, 1'b0);

    // R3: live-only write
    wr(8'h01, 8'h22);
    chk("R3 wiperB live", wiperB, 8'h22);
    chk("R3 no busy live write", busy, 1'b0);
    rd(8'h01, v); chk("R3 live readback", v, 8'h22);
    wr(8'h10, 8'h40);
    chk("R5 shutdown off", shutdown, 1'b0);
    rd(8'h01, v); chk("R3 stored readback", v, 8'h80);
    chk("R3 wiperB kept", wiperB, 8'h22);

    // R8/R6: general-purpose byte and busy length
    wr(8'h07, 8'hA5);
    n = 0;
    while (busy && n < 1000) begin n++; @(posedge clk); #2; end
    chk("R6 busy length", n, N);
    rd(8'h07, v); chk("R8 gp readback", v, 8'hA5);
    chk("R8 wiperA kept", wiperA, 8'h3C);
    wr(8'h0E, 8'h5A);
    waitIdle();
    rd(8'h0E, v); chk("R8 gp top readback", v, 8'h5A);

    // R9: reserved and out-of-map addresses
    wr(8'h0F, 8'h55);
    chk("R9 no busy reserved", busy, 1'b0);
    rd(8'h0F, v); chk("R9 reserved reads zero", v, 8'h00);
    wr(8'h20, 8'h66);
    rd(8'h20, v); chk("R9 high address reads zero", v, 8'h00);

    // R10: soft reset
    wr(8'h10, 8'h80);
    wr(8'h01, 8'h33);
    @(posedge clk); #2 softRstN = 1'b0;
    @(posedge clk); #2 softRstN = 1'b1;
    chk("R10 wiperB reload", wiperB, 8'h80);
    chk("R10 wiperA reload", wiperA, 8'h3C);
    rd(8'h10, v); chk("R10 control default", v, 8'h40);
    rd(8'h07, v); chk("R10 gp kept", v, 8'hA5);
    rd(8'h00, v); chk("R10 stored kept", v, 8'h3C);

    // Random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #2;
      wrEn = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 5))
        0: addr = 8'h00;
        1: addr = 8'h01;
        2: addr = 8'($urandom_range(2, 14));
        3: addr = 8'h10;
        4: addr = 8'h0F;
        default: addr = 8'($urandom_range(17, 255));
      endcase
      wrData = 8'($urandom);
      softRstN = ($urandom_range(0, 40) != 0);
    end
    @(posedge clk); #2 wrEn = 1'b0; softRstN = 1'b1;

    // R1: a second power-on reset restores factory contents
    porRstN = 1'b0;
    @(posedge clk); #2 porRstN = 1'b1;
    rd(8'h00, v); chk("R1 stored A factory", v, 8'h80);
    rd(8'h07, v); chk("R1 gp factory", v, 8'h00);
    chk("R1 wiperA factory", wiperA, 8'h80);

    @(posedge clk); #2;
    finishRun();
  end
endmodule